// File: doc/BRIEF.md
# Port Pin-Change Interrupt Controller

This block watches a group of general-purpose input pins and raises one interrupt request when any pin that software has armed shows a transition of the chosen direction. Every pin first passes through a two-stage synchronizer. Each synchronized pin then goes to an edge detector. A per-pin polarity bit decides whether a rising or a falling transition counts as active. An active transition sets a sticky flag bit for that pin. The flag stays set until software clears it.

Software reaches three registers over a plain synchronous bus. The bus has an address, a write strobe, write data and read data. Read data depends combinationally on the address. A write takes effect at the clock edge where the strobe is high.

| Address | Register | Access |
|---|---|---|
| 0 | Arm mask | read/write |
| 1 | Flags | read; writing 1 clears a bit |
| 2 | Polarity | read/write |
| 3 | Unmapped | reads zero; writes are ignored |

A pin whose arm bit is 0 still records its flag. The arm bit only decides whether that flag reaches the interrupt output.

Top module: `pinchg_irq_ctrl`

## Requirements
- R1: After reset, the arm mask, the flags and the polarity register all read 0, and `irq_o` is low.
- R2: A write to address 0 loads the arm mask, and a read from address 0 returns it. Writes to any other address leave the arm mask unchanged.
- R3: A write to address 2 loads the polarity register, and a read from address 2 returns it. A polarity bit of 1 makes a rising transition active for that pin. A bit of 0 makes a falling transition active.
- R4: An active transition on a pin sets that pin's flag. The flag reads 1 after the third rising clock edge that follows the pin change, and not earlier.
- R5: A transition in the inactive direction leaves the flag unchanged.
- R6: A pin whose arm bit is 0 still sets its flag on an active transition.
- R7: Writing to address 1 clears each flag bit whose write-data bit is 1. Bits written with 0 keep their value. A write to the flag address never sets a flag.
- R8: When an active transition and a clearing write hit the same flag bit in the same cycle, the flag ends up 1.
- R9: `irq_o` is high exactly when some pin has both its flag and its arm bit set. It follows register changes with no extra cycle.
- R10: Changing a polarity bit while the pin is steady does not set that pin's flag.
- R11: Address 3 always reads 0. A write to address 3 changes none of the registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_i | input | NPINS | Asynchronous input pins |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | NPINS | Write data |
| bus_rdata | output | NPINS | Read data for `bus_addr` |
| irq_o | output | 1 | Combined interrupt request |

## Verification
Two events can land on the same flag bit in the same cycle: an active transition coming out of the synchronizer, and a clearing write on the bus. The bench sets up this collision on purpose. It changes a pin, then issues the write-1-to-clear so that it lands on exactly the clock edge where the detected transition reaches the flag. It then expects the flag to read 1. A second pass issues the same write with the pin held steady, to show that the clear works on its own. During the random phase the collision also happens by chance, and each cycle is judged against a bench model that applies the same rule.

// File: rtl/pcint_pkg.sv
package pcint_pkg;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        SEL_ARM  = 2'd0,
        SEL_FLAG = 2'd1,
        SEL_POL  = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/pcint_sync.sv
module pcint_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0][W-1:0] stage_d, stage_q;

    always_comb begin
        stage_d[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            stage_d[s] = stage_q[s-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= stage_d;
    end

    assign sync_o = stage_q[LAST];
endmodule

// File: rtl/pcint_edge.sv
module pcint_edge #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] sync_i,
    input  logic [W-1:0] pol_i,
    output logic [W-1:0] act_o
);
    logic [W-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = sync_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end

    // Only transitions of the synchronized input count; polarity picks one direction.
    for (genvar p = 0; p < W; p++) begin : g_pin
        logic rise, fall;
        assign rise     = sync_i[p] & ~prev_q[p];
        assign fall     = ~sync_i[p] & prev_q[p];
        assign act_o[p] = pol_i[p] ? rise : fall;
    end
endmodule

// File: rtl/pcint_regs.sv
module pcint_regs
    import pcint_pkg::*;
#(
    parameter int W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_i,
    input  logic [W-1:0]      wdata_i,
    input  logic [W-1:0]      act_i,
    output logic [W-1:0]      rdata_o,
    output logic [W-1:0]      arm_o,
    output logic [W-1:0]      flag_o,
    output logic [W-1:0]      pol_o,
    output logic              irq_o
);
    typedef struct packed {
        logic [W-1:0] arm;
        logic [W-1:0] flag;
        logic [W-1:0] pol;
    } regs_t;

    regs_t    regs_d, regs_q;
    reg_sel_e sel;

    assign sel = reg_sel_e'(addr_i);

    always_comb begin
        logic [W-1:0] clr;
        regs_d = regs_q;
        clr    = '0;
        if (wr_i) begin
            unique case (sel)
                SEL_ARM:  regs_d.arm = wdata_i;
                SEL_POL:  regs_d.pol = wdata_i;
                SEL_FLAG: clr        = wdata_i;
                default:  ;
            endcase
        end
        // A new edge outranks a clear on the same bit.
        regs_d.flag = (regs_q.flag & ~clr) | act_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    always_comb begin
        unique case (sel)
            SEL_ARM:  rdata_o = regs_q.arm;
            SEL_FLAG: rdata_o = regs_q.flag;
            SEL_POL:  rdata_o = regs_q.pol;
            default:  rdata_o = '0;
        endcase
    end

    assign arm_o  = regs_q.arm;
    assign flag_o = regs_q.flag;
    assign pol_o  = regs_q.pol;
    assign irq_o  = |(regs_q.flag & regs_q.arm);
endmodule

// File: rtl/pinchg_irq_ctrl.sv
module pinchg_irq_ctrl
    import pcint_pkg::*;
#(
    parameter int NPINS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NPINS-1:0]  pin_i,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [NPINS-1:0]  bus_wdata,
    output logic [NPINS-1:0]  bus_rdata,
    output logic              irq_o
);
    logic [NPINS-1:0] sync_vec;
    logic [NPINS-1:0] act_vec;
    logic [NPINS-1:0] arm_vec;
    logic [NPINS-1:0] flag_vec;
    logic [NPINS-1:0] pol_vec;

    pcint_sync #(.W(NPINS), .STAGES(2)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pin_i),
        .sync_o  (sync_vec)
    );

    pcint_edge #(.W(NPINS)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .sync_i (sync_vec),
        .pol_i  (pol_vec),
        .act_o  (act_vec)
    );

    pcint_regs #(.W(NPINS)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr_i  (bus_addr),
        .wr_i    (bus_wr),
        .wdata_i (bus_wdata),
        .act_i   (act_vec),
        .rdata_o (bus_rdata),
        .arm_o   (arm_vec),
        .flag_o  (flag_vec),
        .pol_o   (pol_vec),
        .irq_o   (irq_o)
    );
endmodule

// File: rtl/pcint_chk.sv
module pcint_chk
    import pcint_pkg::*;
#(
    parameter int W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr,
    input logic [ADDR_W-1:0] addr,
    input logic [W-1:0]      wdata,
    input logic [W-1:0]      act,
    input logic [W-1:0]      arm,
    input logic [W-1:0]      pol,
    input logic [W-1:0]      flag
);
    a_r4_edge_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (act != '0) |=> ((flag & $past(act)) == $past(act)));

    a_r5_no_flag_without_edge: assert property (@(posedge clk) disable iff (!rst_n)
        ((flag & ~$past(flag) & ~$past(act)) == '0));

    a_r7_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == SEL_FLAG) |=> ((flag & $past(wdata & ~act)) == '0));

    a_r2_arm_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && addr == SEL_ARM) |=> $stable(arm));

    a_r3_pol_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && addr == SEL_POL) |=> $stable(pol));
endmodule

bind pinchg_irq_ctrl pcint_chk #(.W(NPINS)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (bus_wr),
    .addr  (bus_addr),
    .wdata (bus_wdata),
    .act   (act_vec),
    .arm   (arm_vec),
    .pol   (pol_vec),
    .flag  (flag_vec)
);

// File: tb/sim_pinchg_irq_ctrl.sv
`timescale 1ns/1ps
module sim_pinchg_irq_ctrl;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] pin = '0;
    logic [1:0]   addr = '0;
    logic         wr = 1'b0;
    logic [N-1:0] wdata = '0;
    logic [N-1:0] rdata;
    logic         irq;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // bench model, built from the requirements
    logic [N-1:0] m_s1 = '0, m_s2 = '0, m_p = '0;
    logic [N-1:0] m_arm = '0, m_flag = '0, m_pol = '0;

    always #5 clk = ~clk;

    pinchg_irq_ctrl #(.NPINS(N)) u0 (
        .clk(clk), .rst_n(rst_n), .pin_i(pin), .bus_addr(addr),
        .bus_wr(wr), .bus_wdata(wdata), .bus_rdata(rdata), .irq_o(irq)
    );

    function automatic logic [N-1:0] model_read(input logic [1:0] a);
        case (a)
            2'd0: return m_arm;
            2'd1: return m_flag;
            2'd2: return m_pol;
            default: return '0;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one clock: update model with the driven inputs, then wait to the next falling edge
    task automatic tick();
        logic [N-1:0] ev, clr;
        ev  = m_pol & m_s2 & ~m_p | ~m_pol & ~m_s2 & m_p;
        clr = (wr && addr == 2'd1) ? wdata : '0;
        m_flag = (m_flag & ~clr) | ev;
        if (wr && addr == 2'd0) m_arm = wdata;
        if (wr && addr == 2'd2) m_pol = wdata;
        m_p  = m_s2;
        m_s2 = m_s1;
        m_s1 = pin;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [N-1:0] d);
        addr = a; wr = 1'b1; wdata = d;
        tick();
        wr = 1'b0; wdata = '0;
    endtask

    task automatic read_check(input string req, input logic [1:0] a, input logic [N-1:0] exp);
        addr = a;
        #1;
        check(req, rdata, exp);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        read_check("R1 arm", 2'd0, '0);
        read_check("R1 flag", 2'd1, '0);
        read_check("R1 pol", 2'd2, '0);
        check("R1 irq", irq, 0);

        // R2 / R3 readback
        bus_write(2'd0, 8'h5A);
        read_check("R2 arm readback", 2'd0, 8'h5A);
        bus_write(2'd2, 8'h0F);
        read_check("R3 pol readback", 2'd2, 8'h0F);
        read_check("R2 arm unchanged by pol write", 2'd0, 8'h5A);

        // R11 unmapped address
        bus_write(2'd3, 8'hFF);
        read_check("R11 reads zero", 2'd3, '0);
        read_check("R11 arm untouched", 2'd0, 8'h5A);
        read_check("R11 pol untouched", 2'd2, 8'h0F);
        read_check("R11 flag untouched", 2'd1, '0);

        // R4 rising on pin0 (pol=1): flag after third edge, not before
        pin[0] = 1'b1;
        addr = 2'd1;
        tick(); tick();
        read_check("R4 not after two edges", 2'd1, '0);
        tick();
        read_check("R4 set after three edges", 2'd1, 8'h01);
        check("R9 irq pin0 unarmed", irq, 0);

        // R6 unarmed pin1 (arm bit 1 is 1 in 5A; use pin2, arm bit 0) rising
        pin[2] = 1'b1;
        idle(3);
        read_check("R6 unarmed pin records flag", 2'd1, 8'h05);
        check("R9 irq still low", irq, 0);

        // R5 pin4 is falling-active (pol bit 0): rising ignored
        pin[4] = 1'b1;
        idle(4);
        read_check("R5 inactive edge ignored", 2'd1, 8'h05);
        pin[4] = 1'b0;
        idle(3);
        read_check("R3 falling edge sets pin4", 2'd1, 8'h15);
        check("R9 irq armed pin4", irq, 1);

        // R7 write-1-to-clear; zeros leave bits alone
        bus_write(2'd1, 8'h10);
        read_check("R7 clear pin4 only", 2'd1, 8'h05);
        check("R9 irq drops after clear", irq, 0);
        bus_write(2'd1, 8'h00);
        read_check("R7 zero write no effect", 2'd1, 8'h05);

        // R10 polarity flip on steady pins
        bus_write(2'd2, 8'hF0);
        idle(4);
        read_check("R10 pol change no flag", 2'd1, 8'h05);

        // R8 collision: pin6 rising (pol bit6=1), clear lands on the setting edge
        bus_write(2'd1, 8'hFF);
        pin[6] = 1'b1;
        tick(); tick();
        bus_write(2'd1, 8'h40);
        read_check("R8 set wins over clear", 2'd1, 8'h40);
        check("R9 irq armed pin6", irq, 1);
        bus_write(2'd1, 8'h40);
        read_check("R8 clear alone works", 2'd1, 8'h00);

        // random phase against the model
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 7) == 0) pin = pin ^ N'($urandom);
            wr    = ($urandom_range(0, 3) == 0);
            addr  = 2'($urandom);
            wdata = N'($urandom);
            tick();
            check("R9 irq random", irq, |(m_flag & m_arm));
            check("R2 R7 read random", rdata, model_read(addr));
        end
        wr = 1'b0;

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule